// File: doc/BRIEF.md
# Selectable-Period Watchdog with Deferred Reconfiguration

This block supervises software by counting clock ticks between service strobes. A two-bit select code picks one of three timeout lengths or switches the watchdog off. If the count reaches the selected length before a kick arrives, the block raises a reset pulse of fixed length. It then starts a fresh period.

The select code is written into a pending register through the configuration-write path. The running timer keeps using the active copy. The pending value is copied into the active copy only when a command-complete strobe arrives, or when power-on reset returns both copies to the off code. Software can therefore stage a new period at any time without disturbing the period being timed. A change of the active code restarts the count.

Top module: `wdog_sel_timer`

## Requirements
- R1: After power-on reset (`rst_n_i` low, sampled on a clock edge), `sel_active_o` is 2'b11, `wd_rst_o` is 0, and the pending code is 2'b11, so a later command-complete strobe with no write leaves `sel_active_o` at 2'b11.
- R2: Code 2'b00 selects `TICKS_LONG`, 2'b01 selects `TICKS_MID` and 2'b10 selects `TICKS_SHORT` clock ticks. With no kick, `wd_rst_o` rises exactly that many clock edges after the edge that restarted the count.
- R3: While `sel_active_o` is 2'b11, the counter is held at zero and `wd_rst_o` stays 0.
- R4: A write (`sel_wr_i` high) updates only the pending code, and `sel_active_o` does not change until an edge samples `cmd_done_i` high. At that edge `sel_active_o` takes the pending code held before the edge. A write in the same cycle as the strobe is committed by the next strobe only.
- R5: A kick sampled while `wd_rst_o` is low restarts the count at that edge. `wd_rst_o` then rises the selected number of edges after the kick edge.
- R6: When `sel_active_o` changes, the count restarts at the following edge. Any reset pulse in progress ends at that edge.
- R7: A reset pulse lasts exactly `PULSE_LEN` cycles, and kicks during the pulse do not shorten it.
- R8: After a pulse ends, counting restarts from zero. The next pulse rises the selected number of edges after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low power-on reset |
| sel_wr_i | input | 1 | Write strobe for the pending select code |
| sel_wdata_i | input | 2 | Select code to be staged |
| cmd_done_i | input | 1 | Command-complete strobe; commits the pending code |
| kick_i | input | 1 | Service strobe; restarts the count |
| wd_rst_o | output | 1 | Watchdog reset pulse |
| sel_active_o | output | 2 | Select code currently timing |

## Verification
A committed code is visible one edge after the commit edge. The restart caused by that change follows one edge later, so a timeout after a commit is due one edge more than the selected length. A kick restarts the count on its own edge, and a pulse falls exactly `PULSE_LEN` edges after it rises. The bench drives every strobe on a falling edge and samples on falling edges. It counts the rising edges between stimulus and response and compares that count with the value each requirement gives.

// File: rtl/wdog_sel_pkg.sv
// Package: shared select-code type for the watchdog.
// Assumes: the code is two bits wide and code 2'b11 means off.
package wdog_sel_pkg;

    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/wdog_sel_cfg.sv
// Module: holds the pending and active select codes.
// Assumes: a commit copies the pending value held before the edge, and reset
// returns both registers to the off code.
module wdog_sel_cfg
    import wdog_sel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       sel_wr_i,
    input  logic [1:0] sel_wdata_i,
    input  logic       cmd_done_i,
    output logic [1:0] pend_sel_o,
    output logic [1:0] act_sel_o
);

    wd_sel_e pend_q;
    wd_sel_e act_q;

    // Capture a newly staged code on the write strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)      pend_q <= SEL_OFF;
        else if (sel_wr_i) pend_q <= wd_sel_e'(sel_wdata_i);
    end

    // Promote the staged code to the active copy at a command boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)        act_q <= SEL_OFF;
        else if (cmd_done_i) act_q <= pend_q;
    end

    assign pend_sel_o = pend_q;
    assign act_sel_o  = act_q;

endmodule

// File: rtl/wdog_limit_sel.sv
// Module: maps the active select code to a timeout length and an enable flag.
// Assumes: all three lengths are at least 1 and fit in CNT_W bits.
module wdog_limit_sel
    import wdog_sel_pkg::*;
#(
    parameter int TICKS_LONG  = 700,
    parameter int TICKS_MID   = 300,
    parameter int TICKS_SHORT = 100,
    parameter int CNT_W       = 10
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             enabled_o
);

    // Decode the select code into a tick count.
    always_comb begin
        enabled_o = 1'b1;
        unique case (wd_sel_e'(sel_i))
            SEL_LONG:  limit_o = CNT_W'(TICKS_LONG);
            SEL_MID:   limit_o = CNT_W'(TICKS_MID);
            SEL_SHORT: limit_o = CNT_W'(TICKS_SHORT);
            default: begin
                limit_o   = CNT_W'(TICKS_LONG);
                enabled_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wdog_period_cnt.sv
// Module: counts ticks towards the limit and produces the reset pulse.
// Assumes: the limit is at least 1 and PULSE_LEN is at least 1. Priority is
// disable or select change, then pulse in progress, then kick, then count.
module wdog_period_cnt
    import wdog_sel_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [1:0]       act_sel_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             enabled_i,
    input  logic             kick_i,
    output logic             wd_rst_o
);

    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LEN - 1);

    logic [1:0]       seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pcnt_q;
    logic             rst_q;
    logic             sel_moved;

    // Flag a select code that differs from the one last timed.
    assign sel_moved = (act_sel_i != seen_q);

    // Advance the period counter or the pulse counter.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            seen_q <= SEL_OFF;
            cnt_q  <= '0;
            pcnt_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            seen_q <= act_sel_i;
            if (!enabled_i || sel_moved) begin
                cnt_q  <= '0;
                pcnt_q <= '0;
                rst_q  <= 1'b0;
            end else if (rst_q) begin
                if (pcnt_q == PULSE_LAST) begin
                    rst_q  <= 1'b0;
                    pcnt_q <= '0;
                    cnt_q  <= '0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end else if (kick_i) begin
                cnt_q <= '0;
            end else if (cnt_q == limit_i - 1'b1) begin
                rst_q  <= 1'b1;
                cnt_q  <= '0;
                pcnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wd_rst_o = rst_q;

endmodule

// File: rtl/wdog_sel_timer.sv
// Module: top level of the selectable-period watchdog.
// Assumes: all strobes are synchronous to clk_i and TICKS_LONG is the largest
// of the three lengths.
module wdog_sel_timer #(
    parameter int TICKS_LONG  = 700,
    parameter int TICKS_MID   = 300,
    parameter int TICKS_SHORT = 100,
    parameter int PULSE_LEN   = 4
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       sel_wr_i,
    input  logic [1:0] sel_wdata_i,
    input  logic       cmd_done_i,
    input  logic       kick_i,
    output logic       wd_rst_o,
    output logic [1:0] sel_active_o
);

    localparam int CNT_W = $clog2(TICKS_LONG + 1);

    logic [1:0]       pend_sel;
    logic [1:0]       act_sel;
    logic [CNT_W-1:0] limit;
    logic             enabled;

    // Staged and active select registers.
    wdog_sel_cfg u_cfg (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sel_wr_i   (sel_wr_i),
        .sel_wdata_i(sel_wdata_i),
        .cmd_done_i (cmd_done_i),
        .pend_sel_o (pend_sel),
        .act_sel_o  (act_sel)
    );

    // Select-code decode.
    wdog_limit_sel #(
        .TICKS_LONG (TICKS_LONG),
        .TICKS_MID  (TICKS_MID),
        .TICKS_SHORT(TICKS_SHORT),
        .CNT_W      (CNT_W)
    ) u_limit (
        .sel_i    (act_sel),
        .limit_o  (limit),
        .enabled_o(enabled)
    );

    // Period and pulse counting.
    wdog_period_cnt #(
        .CNT_W    (CNT_W),
        .PULSE_LEN(PULSE_LEN)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .act_sel_i(act_sel),
        .limit_i  (limit),
        .enabled_i(enabled),
        .kick_i   (kick_i),
        .wd_rst_o (wd_rst_o)
    );

    assign sel_active_o = act_sel;

endmodule

// File: rtl/wdog_sel_timer_chk.sv
// Module: property checker for the watchdog, bound into the top module.
// Assumes: it observes the ports plus the staged select code.
module wdog_sel_timer_chk #(
    parameter int PULSE_LEN = 4
) (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       cmd_done_i,
    input logic       kick_i,
    input logic [1:0] pend_sel_i,
    input logic [1:0] sel_active_i,
    input logic       wd_rst_i
);

    localparam int RW = $clog2(PULSE_LEN + 2) + 1;
    localparam logic [RW-1:0] RUN_MAX = '1;

    logic [RW-1:0] run_q;

    // Count the consecutive cycles for which the reset output has been high.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                         run_q <= '0;
        else if (wd_rst_i && run_q != RUN_MAX) run_q <= run_q + 1'b1;
        else if (!wd_rst_i)                   run_q <= '0;
    end

    p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sel_active_i == 2'b11 && $past(sel_active_i) == 2'b11) |-> !wd_rst_i);

    p_hold_until_done_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cmd_done_i |=> $stable(sel_active_i));

    p_commit_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cmd_done_i |=> (sel_active_i == $past(pend_sel_i)));

    p_kick_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (kick_i && !wd_rst_i) |=> !wd_rst_i);

    p_change_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sel_active_i != $past(sel_active_i)) |=> !wd_rst_i);

    p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wd_rst_i |-> (run_q < RW'(PULSE_LEN)));

endmodule

bind wdog_sel_timer wdog_sel_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .cmd_done_i  (cmd_done_i),
    .kick_i      (kick_i),
    .pend_sel_i  (pend_sel),
    .sel_active_i(sel_active_o),
    .wd_rst_i    (wd_rst_o)
);

// File: tb/wdog_sel_timer_tb_top.sv
module wdog_sel_timer_tb_top;

    localparam int T_LONG  = 70;
    localparam int T_MID   = 30;
    localparam int T_SHORT = 10;
    localparam int T_PULSE = 3;

    // Table of {select code, expected ticks}.
    localparam int VEC [3][2] = '{'{2, T_SHORT}, '{1, T_MID}, '{0, T_LONG}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       cmd_done = 1'b0;
    logic       kick = 1'b0;
    logic       wd_rst;
    logic [1:0] sel_active;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wdog_sel_timer #(
        .TICKS_LONG (T_LONG),
        .TICKS_MID  (T_MID),
        .TICKS_SHORT(T_SHORT),
        .PULSE_LEN  (T_PULSE)
    ) dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .sel_wr_i    (sel_wr),
        .sel_wdata_i (sel_wdata),
        .cmd_done_i  (cmd_done),
        .kick_i      (kick),
        .wd_rst_o    (wd_rst),
        .sel_active_o(sel_active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic commit();
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    // Edges from now until wd_rst is seen high.
    task automatic measure_rise(output int k);
        k = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            k++;
            if (wd_rst) break;
        end
    endtask

    // Cycles wd_rst stays high, counting the one already seen.
    task automatic measure_high(output int w);
        w = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!wd_rst) break;
            w++;
        end
    endtask

    task automatic watch(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wd_rst) hits++;
        end
    endtask

    initial begin
        int k, w, hits, acc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset wd_rst", int'(wd_rst), 0);
        check("R1 reset select", int'(sel_active), 3);

        watch(200, hits);
        check("R3 off after reset", hits, 0);

        write_sel(2'b10);
        watch(3 * T_LONG, hits);
        check("R4 no commit, no pulse", hits, 0);
        check("R4 no commit, select held", int'(sel_active), 3);

        // Table walk: program, time first pulse, pulse width, next period.
        for (int v = 0; v < 3; v++) begin
            write_sel(2'(VEC[v][0]));
            commit();
            check("R4 commit visible", int'(sel_active), VEC[v][0]);
            measure_rise(k);
            check("R2 timeout after commit", k, VEC[v][1] + 1);
            measure_high(w);
            check("R7 pulse width", w, T_PULSE);
            measure_rise(k);
            check("R8 period after pulse", k, VEC[v][1]);
            measure_high(w);
        end

        // Same-cycle write and commit: old staged code wins.
        sel_wr = 1'b1; sel_wdata = 2'b01; cmd_done = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0; cmd_done = 1'b0;
        check("R4 same-cycle commit keeps old", int'(sel_active), 0);
        commit();
        check("R4 next commit takes new", int'(sel_active), 1);

        // Regular kicks hold off the pulse.
        acc = 0;
        for (int i = 0; i < 6; i++) begin
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            watch(19, hits);
            acc += hits;
        end
        check("R5 kicked, no pulse", acc, 0);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        measure_rise(k);
        check("R5 timeout after last kick", k, T_MID);

        // Kick during the pulse does not shorten it.
        w = 1;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        if (wd_rst) begin
            w++;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!wd_rst) break;
                w++;
            end
        end
        check("R7 kick in pulse ignored", w, T_PULSE);

        // Select change aborts a pulse in progress.
        write_sel(2'b11);
        measure_rise(k);
        commit();
        @(negedge clk);
        check("R6 pulse aborted by change", int'(wd_rst), 0);
        check("R6 select now off", int'(sel_active), 3);
        watch(200, hits);
        check("R3 off holds quiet", hits, 0);

        // Reset while running.
        write_sel(2'b10);
        commit();
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-run reset select", int'(sel_active), 3);
        check("R1 mid-run reset wd_rst", int'(wd_rst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        commit();
        check("R1 staged code cleared", int'(sel_active), 3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule